// File: doc/BRIEF.md
# Two-Phase Sample Combiner

This block builds one wide trace sample out of signals that a target presents at two separate moments. A park strobe marks the first moment: the first-phase signals are captured into a holding store. A later commit strobe marks the second moment: the held bits are merged with the signals live at that instant. The merged word is then presented as one sample, qualified by a single-cycle valid.

The 64 channel inputs form four 16-bit lanes. Lane 0 is bits [15:0], lane 1 is [31:16], lane 2 is [47:32] and lane 3 is [63:48]. A 2-bit mode picks how the first phase is parked. In the shifted modes, a lane's low byte is shared between the two phases. At park time that byte is moved into the lane's high byte. In the whole-lane modes, complete lanes are held unchanged. Lanes that take no part in the first phase are always taken live at commit.

The strobes come from external clock-equation logic and are sampled on the block clock.

Top module: `two_phase_combiner`

## Requirements
- R1: While reset is asserted and on the first clock after it, `smp_valid_o` is 0 and `smp_data_o` is 0. Any value parked before reset is discarded.
- R2: `smp_valid_o` is high for exactly the one clock that follows each clock in which `commit_stb_i` is high. The merged sample appears on `smp_data_o` in that same clock.
- R3: Mode 0, narrow shifted. The output is built as follows:
  - bits [15:8] are bits [7:0] as they were at the last park strobe;
  - bits [7:0] are bits [7:0] at the commit strobe;
  - bits [63:16] are taken at the commit strobe.
- R4: Mode 1, wide shifted. Lanes 0, 1 and 2 are each built as R3 describes for lane 0. Lane 3, bits [63:48], is taken at the commit strobe.
- R5: Mode 2, narrow whole-lane. Bits [15:0] are taken at the last park strobe. Bits [63:16] are taken at the commit strobe.
- R6: Mode 3, wide whole-lane. Bits [31:0] are taken at the last park strobe. Bits [63:32] are taken at the commit strobe.
- R7: If several park strobes come before a commit strobe, only the most recent one is used.
- R8: A commit strobe with no park strobe since reset or since the previous commit uses zero for every parked bit.
- R9: Park and commit may be high in the same clock. The sample emitted then uses the value parked before that clock. The new park value is kept for the next commit.
- R10: `smp_data_o` changes only in the clock after a commit strobe. In every other clock it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Parking layout, 0 to 3 as in R3 to R6 |
| chan_i | input | 64 | Channel inputs, four 16-bit lanes |
| park_stb_i | input | 1 | First-phase strobe, one clock per event |
| commit_stb_i | input | 1 | Second-phase strobe, one clock per event |
| smp_valid_o | output | 1 | One-clock qualifier of a combined sample |
| smp_data_o | output | 64 | Combined sample |

## Verification
The two functions that can fall in the same clock are parking a new first phase and committing the previous one. The bench provokes this by raising both strobes together after an earlier park. It expects the emitted sample to carry the earlier parked bits. It then sends a lone commit and expects that sample to carry the bits parked in the shared clock. Both expectations come from the bench's own model of the layouts. This pairing is repeated for every mode over pseudo-random channel words.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT_NARROW = 2'd0,
    MODE_SHIFT_WIDE   = 2'd1,
    MODE_WHOLE_NARROW = 2'd2,
    MODE_WHOLE_WIDE   = 2'd3
  } tpc_mode_e;

  typedef enum logic [1:0] {
    ROLE_LIVE  = 2'd0,
    ROLE_SHIFT = 2'd1,
    ROLE_HOLD  = 2'd2
  } tpc_role_e;

  // Part a lane plays for a given mode; counts give how many low lanes join phase one.
  function automatic tpc_role_e lane_role(input tpc_mode_e   mode,
                                          input int unsigned lane,
                                          input int unsigned shift_narrow,
                                          input int unsigned shift_wide,
                                          input int unsigned hold_narrow,
                                          input int unsigned hold_wide);
    tpc_role_e r;
    case (mode)
      MODE_SHIFT_NARROW: r = (lane < shift_narrow) ? ROLE_SHIFT : ROLE_LIVE;
      MODE_SHIFT_WIDE:   r = (lane < shift_wide)   ? ROLE_SHIFT : ROLE_LIVE;
      MODE_WHOLE_NARROW: r = (lane < hold_narrow)  ? ROLE_HOLD  : ROLE_LIVE;
      default:           r = (lane < hold_wide)    ? ROLE_HOLD  : ROLE_LIVE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tpc_role_decode.sv
module tpc_role_decode
  import tpc_pkg::*;
#(
  parameter int unsigned NGRP         = 4,
  parameter int unsigned SHIFT_NARROW = 1,
  parameter int unsigned SHIFT_WIDE   = 3,
  parameter int unsigned HOLD_NARROW  = 1,
  parameter int unsigned HOLD_WIDE    = 2
) (
  input  tpc_mode_e mode_i,
  output tpc_role_e role_o [NGRP]
);

  for (genvar g = 0; g < NGRP; g++) begin : g_role
    assign role_o[g] = lane_role(mode_i, int'(g), SHIFT_NARROW, SHIFT_WIDE,
                                 HOLD_NARROW, HOLD_WIDE);
  end

endmodule

// File: rtl/tpc_lane.sv
module tpc_lane
  import tpc_pkg::*;
#(
  parameter int unsigned GW = 16   // lane width, even
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tpc_role_e     role_i,
  input  logic [GW-1:0] live_i,
  input  logic          park_i,
  input  logic          commit_i,
  output logic [GW-1:0] merged_o
);

  localparam int unsigned HALF = GW / 2;

  logic [GW-1:0] hold_q;

  // Value stored at a park strobe.
  function automatic logic [GW-1:0] park_val(input tpc_role_e r, input logic [GW-1:0] v);
    case (r)
      ROLE_SHIFT: return {v[HALF-1:0], {(GW-HALF){1'b0}}};
      ROLE_HOLD:  return v;
      default:    return '0;
    endcase
  endfunction

  // Lane contribution to the combined sample.
  function automatic logic [GW-1:0] merge_val(input tpc_role_e r, input logic [GW-1:0] h,
                                              input logic [GW-1:0] v);
    case (r)
      ROLE_SHIFT: return {h[GW-1:HALF], v[HALF-1:0]};
      ROLE_HOLD:  return h;
      default:    return v;
    endcase
  endfunction

  // A park in the same clock as a commit wins: the new phase is kept for the next sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (park_i)   hold_q <= park_val(role_i, live_i);
    else if (commit_i) hold_q <= '0;
  end

  assign merged_o = merge_val(role_i, hold_q, live_i);

  // R3/R4: a shifted lane parks its low half in the high half
  p_shift_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (park_i && role_i == ROLE_SHIFT) |=> hold_q[GW-1:HALF] == $past(live_i[HALF-1:0]));

  // R5/R6: a whole lane parks unchanged
  p_whole_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (park_i && role_i == ROLE_HOLD) |=> hold_q == $past(live_i));

  // R8: a commit without park leaves nothing parked
  p_drop_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !park_i) |=> hold_q == '0);

  // R7: without strobes the parked value stays
  p_hold_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!park_i && !commit_i) |=> $stable(hold_q));

endmodule

// File: rtl/tpc_sample_reg.sv
module tpc_sample_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) data_o <= data_i;
    end
  end

  // R10: output word held between commits
  p_data_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(data_o));

  // R2: no back-to-back valid without back-to-back loads
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !load_i) |=> !valid_o);

endmodule

// File: rtl/two_phase_combiner.sv
module two_phase_combiner
  import tpc_pkg::*;
#(
  parameter int unsigned NGRP         = 4,
  parameter int unsigned GW           = 16,
  parameter int unsigned SHIFT_NARROW = 1,
  parameter int unsigned SHIFT_WIDE   = 3,
  parameter int unsigned HOLD_NARROW  = 1,
  parameter int unsigned HOLD_WIDE    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic [NGRP*GW-1:0]   chan_i,
  input  logic                 park_stb_i,
  input  logic                 commit_stb_i,
  output logic                 smp_valid_o,
  output logic [NGRP*GW-1:0]   smp_data_o
);

  localparam int unsigned CH = NGRP * GW;

  tpc_mode_e      mode_e;
  tpc_role_e      roles [NGRP];
  logic [CH-1:0]  merged;
  logic           ev_park;
  logic           ev_commit;
  logic           ev_overlap;

  assign mode_e     = tpc_mode_e'(mode_i);
  assign ev_park    = park_stb_i;
  assign ev_commit  = commit_stb_i;
  assign ev_overlap = ev_park && ev_commit;

  tpc_role_decode #(
    .NGRP(NGRP), .SHIFT_NARROW(SHIFT_NARROW), .SHIFT_WIDE(SHIFT_WIDE),
    .HOLD_NARROW(HOLD_NARROW), .HOLD_WIDE(HOLD_WIDE)
  ) u_roles (
    .mode_i (mode_e),
    .role_o (roles)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_lane
    tpc_lane #(.GW(GW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .role_i   (roles[g]),
      .live_i   (chan_i[g*GW +: GW]),
      .park_i   (ev_park),
      .commit_i (ev_commit),
      .merged_o (merged[g*GW +: GW])
    );
  end

  tpc_sample_reg #(.W(CH)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (ev_commit),
    .data_i  (merged),
    .valid_o (smp_valid_o),
    .data_o  (smp_data_o)
  );

  // R2: valid only after a commit
  p_valid_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> $past(ev_commit));

  // R9: overlapping strobes still emit a sample
  p_overlap_emits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overlap |=> smp_valid_o);

  // R1: reset state visible at the outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!smp_valid_o && smp_data_o == '0);
    end
  end

endmodule

// File: tb/tb_two_phase_combiner.sv
module tb_two_phase_combiner;

  localparam int CLK_PERIOD = 10;
  localparam int BUDGET     = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [63:0] chan_i = '0;
  logic        park_stb_i = 1'b0;
  logic        commit_stb_i = 1'b0;
  logic        smp_valid_o;
  logic [63:0] smp_data_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] parked = '0;   // bench model of the first phase (raw word at park)
  logic [63:0] last_out = '0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  two_phase_combiner dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .chan_i(chan_i),
    .park_stb_i(park_stb_i), .commit_stb_i(commit_stb_i),
    .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o)
  );

  function automatic logic [63:0] next_word(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  // Expected sample from parked word s and commit-time word m.
  function automatic logic [63:0] expect_word(input logic [1:0] md, input logic [63:0] s,
                                              input logic [63:0] m);
    case (md)
      2'd0: return {m[63:16], s[7:0], m[7:0]};
      2'd1: return {m[63:48], s[39:32], m[39:32], s[23:16], m[23:16], s[7:0], m[7:0]};
      2'd2: return {m[63:16], s[15:0]};
      default: return {m[63:32], s[31:0]};
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock with the given strobes; outputs checked just after the edge.
  task automatic cycle(input logic p, input logic c, input logic [63:0] d, input string tag);
    logic [63:0] want;
    @(negedge clk);
    park_stb_i = p; commit_stb_i = c; chan_i = d;
    want = expect_word(mode_i, parked, d);
    @(posedge clk);
    #1;
    park_stb_i = 1'b0; commit_stb_i = 1'b0;
    check(smp_valid_o == c, {tag, " R2 valid"}, {63'd0, smp_valid_o}, {63'd0, c});
    if (c) begin
      check(smp_data_o == want, tag, smp_data_o, want);
      last_out = want;
    end else begin
      check(smp_data_o == last_out, {tag, " R10 held"}, smp_data_o, last_out);
    end
    if (p) parked = d;
    else if (c) parked = '0;
  endtask

  function automatic logic [63:0] rnd();
    seed = next_word(seed);
    return seed;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!smp_valid_o && smp_data_o == '0, "R1 in reset", smp_data_o, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(!smp_valid_o && smp_data_o == '0, "R1 after reset", smp_data_o, 64'd0);

    for (int md = 0; md < 4; md++) begin
      mode_i = 2'(md);
      for (int it = 0; it < 24; it++) begin
        cycle(1'b0, 1'b0, rnd(), "R10 idle");
        cycle(1'b0, 1'b1, rnd(), "R8 commit alone");
        cycle(1'b1, 1'b0, rnd(), mode_tag(mode_i));
        cycle(1'b0, 1'b0, rnd(), "R10 gap");
        cycle(1'b0, 1'b1, rnd(), mode_tag(mode_i));
        cycle(1'b1, 1'b0, rnd(), "R7 first park");
        cycle(1'b1, 1'b0, rnd(), "R7 second park");
        cycle(1'b0, 1'b1, rnd(), "R7 overwrite");
        cycle(1'b1, 1'b0, rnd(), "R9 pre park");
        cycle(1'b1, 1'b1, rnd(), "R9 overlap");
        cycle(1'b0, 1'b1, rnd(), "R9 after overlap");
        cycle(1'b1, 1'b1, rnd(), "R9 overlap from empty");
        cycle(1'b0, 1'b1, rnd(), "R9 drain");
      end
    end

    // Reset discards a parked value.
    mode_i = 2'd3;
    cycle(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 park before reset");
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check(!smp_valid_o && smp_data_o == '0, "R1 mid reset", smp_data_o, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    parked = '0; last_out = '0;
    cycle(1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, "R1 commit after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (BUDGET) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule